// File: doc/BRIEF.md
# Interrupt Request Service and End-of-Interrupt Engine

This block keeps one request bit for each of a small set of interrupt pins and decides when each pin may be delivered. The decision uses that pin's redirection entry, which the surrounding logic supplies as plain configuration inputs: vector, destination, destination mode, delivery mode, trigger type and mask. Each granted delivery leaves the block as a single-cycle message. The message carries the vector, the destination and both modes. A fabric outside this block carries it to the processors.

Interrupt sources talk to the block through two strobes per pin, one that raises the line and one that drops it. Processors acknowledge by presenting an end-of-interrupt vector. A level-triggered pin stays blocked by its remote-request flag until an acknowledgment with a matching vector arrives. If the line is still high at that point, the pin is delivered again at once.

A pin can keep its line high through many back-to-back acknowledgments. Each pin counts these in a row. When the count reaches a limit, the block stops redelivering at once and starts a programmable down-counter. When the counter expires, every level pin that is still requesting and not blocked is serviced again. The delay gives a misbehaving handler room to make progress.

Top module: `irq_service_engine`

## Requirements
- R1: A drop strobe on a pin clears its request bit (shown on `reqState`) at the next edge. When raise and drop arrive together, raise wins.
- R2: On an edge-triggered pin, a raise while the request bit is clear sets the bit and produces exactly one delivery. A raise while the bit is already set is merged and produces no delivery.
- R3: A delivery attempt is refused when the pin's mask is 1, or when the pin is level-triggered and its remote flag is 1. A refused attempt is discarded, so clearing the mask later does not deliver by itself.
- R4: A delivery of a level-triggered pin sets that pin's remote flag (`remoteIrr`). An edge-triggered delivery leaves the flag unchanged.
- R5: An end-of-interrupt acts on every level-triggered pin whose vector equals the presented vector. It clears the remote flag. If the pin is unmasked and still requesting, the pin is redelivered. Edge-triggered pins and pins with other vectors are unaffected.
- R6: Each pin counts acknowledgments in a row that find it unmasked and requesting. When the count reaches STORM_LIMIT (default 10000), the count returns to 0 and no immediate redelivery occurs. Instead, the delay timer is started.
- R7: An acknowledgment that finds the pin masked or not requesting clears that pin's count.
- R8: When a pin's entry is rewritten (`cfgWrite`) as level-triggered while its request bit is set, an attempt is made at once. Rewriting it as edge-triggered clears its remote flag.
- R9: The delay timer loads `delayCycles` (0 counts as 1) and does not reload while it is running. When it expires, it starts an attempt on every level-triggered pin that is requesting and has its remote flag clear.
- R10: Attempts that become eligible together are delivered one per cycle, lowest pin number first.
- R11: `dlvValid` is high for one cycle per delivery. It appears in the cycle after the second clock edge counted from the edge that sampled the triggering strobe. During that cycle, `dlvPin`, `dlvVector`, `dlvDest`, `dlvDestMode`, `dlvDelivMode` and `dlvLevel` (1 = level) carry the granted pin's entry.
- R12: After reset, all request bits, remote flags, counts and the timer are clear, and `dlvValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqRaise | input | NUM_PINS | Per-pin line-raise strobe |
| reqDrop | input | NUM_PINS | Per-pin line-drop strobe |
| cfgVector | input | NUM_PINS*VEC_W | Vector of each entry, pin 0 in the low bits |
| cfgDest | input | NUM_PINS*DEST_W | Destination of each entry |
| cfgDelivMode | input | NUM_PINS*3 | Delivery mode of each entry |
| cfgDestMode | input | NUM_PINS | Destination mode of each entry |
| cfgLevelTrig | input | NUM_PINS | 1 = level-triggered, 0 = edge-triggered |
| cfgMask | input | NUM_PINS | 1 = pin masked |
| cfgWrite | input | NUM_PINS | Pulse: entry of that pin was rewritten this cycle |
| eoiValid | input | 1 | End-of-interrupt present |
| eoiVector | input | VEC_W | Vector being acknowledged |
| delayCycles | input | DLY_W | Postponement length in cycles |
| dlvValid | output | 1 | Delivery message valid |
| dlvPin | output | PIN_W | Pin being delivered |
| dlvVector | output | VEC_W | Delivered vector |
| dlvDest | output | DEST_W | Delivered destination |
| dlvDestMode | output | 1 | Delivered destination mode |
| dlvDelivMode | output | 3 | Delivered delivery mode |
| dlvLevel | output | 1 | Delivered trigger type |
| remoteIrr | output | NUM_PINS | Per-pin remote flag |
| reqState | output | NUM_PINS | Per-pin request bit |

## Verification
Several kinds of internal fault show up at the ports, each in its own way:
- A stuck or lost remote flag shows on `remoteIrr` at the next edge. It also shows as an extra level delivery, or a missing one, within two cycles of the next raise or acknowledgment.
- A wrong storm count does not show until the streak ends. The deferral then lands one acknowledgment early or late, so an immediate delivery appears where none is due, or the reverse.
- A timer fault moves the deferred deliveries out of their window about `delayCycles` after the tripping acknowledgment.
- A wrong arbitration order appears as swapped pins in the delivery stream.

// File: rtl/irqsvc_pkg.sv
package irqsvc_pkg;
  // Width of the pin index carried between control and datapath (up to 64 pins)
  localparam int PIN_IDX_W = 6;

  typedef struct packed {
    logic                 grantValid;
    logic [PIN_IDX_W-1:0] grantPin;
    logic                 delayFire;
  } svcStrobe_t;
endpackage

// File: rtl/irqsvc_dp.sv
module irqsvc_dp
  import irqsvc_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int VEC_W       = 8,
  parameter int DEST_W      = 8,
  parameter int STORM_LIMIT = 10000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PINS-1:0]        reqRaise,
  input  logic [NUM_PINS-1:0]        reqDrop,
  input  logic [NUM_PINS*VEC_W-1:0]  cfgVector,
  input  logic [NUM_PINS*DEST_W-1:0] cfgDest,
  input  logic [NUM_PINS*3-1:0]      cfgDelivMode,
  input  logic [NUM_PINS-1:0]        cfgDestMode,
  input  logic [NUM_PINS-1:0]        cfgLevelTrig,
  input  logic [NUM_PINS-1:0]        cfgMask,
  input  logic [NUM_PINS-1:0]        cfgWrite,
  input  logic                       eoiValid,
  input  logic [VEC_W-1:0]           eoiVector,
  input  svcStrobe_t                 strobe,
  output logic [NUM_PINS-1:0]        eligible,
  output logic                       stormAny,
  output logic                       dlvValid,
  output logic [((NUM_PINS > 1) ? $clog2(NUM_PINS) : 1)-1:0] dlvPin,
  output logic [VEC_W-1:0]           dlvVector,
  output logic [DEST_W-1:0]          dlvDest,
  output logic                       dlvDestMode,
  output logic [2:0]                 dlvDelivMode,
  output logic                       dlvLevel,
  output logic [NUM_PINS-1:0]        remoteIrr,
  output logic [NUM_PINS-1:0]        reqState
);
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int CNT_W = $clog2(STORM_LIMIT + 1);

  logic [NUM_PINS-1:0] stormVec;
  logic [NUM_PINS-1:0] grantVec;

  genvar i;
  for (i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [VEC_W-1:0] pinVec;
    logic             eoiHit, takeAgain, stormTrip, setPend, granted;
    logic [CNT_W-1:0] cnt, cntNext;
    logic             irr, rirr, pend;

    assign pinVec = cfgVector[i*VEC_W +: VEC_W];

    always_comb begin
      eoiHit    = eoiValid && cfgLevelTrig[i] && (pinVec == eoiVector);
      granted   = strobe.grantValid && (strobe.grantPin == PIN_IDX_W'(i));
      takeAgain = 1'b0;
      stormTrip = 1'b0;
      cntNext   = cnt;
      if (eoiHit) begin
        if (!cfgMask[i] && irr) begin
          if (cnt == CNT_W'(STORM_LIMIT - 1)) begin
            cntNext   = '0;
            stormTrip = 1'b1;
          end else begin
            cntNext   = cnt + 1'b1;
            takeAgain = 1'b1;
          end
        end else begin
          cntNext = '0;
        end
      end
      setPend = (reqRaise[i] && (cfgLevelTrig[i] || !irr))
             || (cfgWrite[i] && cfgLevelTrig[i] && irr)
             || takeAgain
             || (strobe.delayFire && cfgLevelTrig[i] && irr && !rirr);
    end

    assign eligible[i] = pend && !cfgMask[i] && !(cfgLevelTrig[i] && rirr);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        irr  <= 1'b0;
        rirr <= 1'b0;
        pend <= 1'b0;
        cnt  <= '0;
      end else begin
        if (reqRaise[i])     irr <= 1'b1;
        else if (reqDrop[i]) irr <= 1'b0;
        pend <= (pend && eligible[i] && !granted) || setPend;
        if (granted && cfgLevelTrig[i])                        rirr <= 1'b1;
        else if (eoiHit || (cfgWrite[i] && !cfgLevelTrig[i]))  rirr <= 1'b0;
        cnt <= cntNext;
      end
    end

    assign remoteIrr[i] = rirr;
    assign reqState[i]  = irr;
    assign stormVec[i]  = stormTrip;
    assign grantVec[i]  = granted;
  end

  assign stormAny = |stormVec;

  logic [PIN_W-1:0]  selPin;
  logic [VEC_W-1:0]  selVec;
  logic [DEST_W-1:0] selDest;
  logic              selDm, selLvl;
  logic [2:0]        selMode;

  always_comb begin
    selPin  = '0;
    selVec  = '0;
    selDest = '0;
    selDm   = 1'b0;
    selLvl  = 1'b0;
    selMode = '0;
    for (int k = 0; k < NUM_PINS; k++) begin
      if (grantVec[k]) begin
        selPin  = PIN_W'(k);
        selVec  = cfgVector[k*VEC_W +: VEC_W];
        selDest = cfgDest[k*DEST_W +: DEST_W];
        selDm   = cfgDestMode[k];
        selLvl  = cfgLevelTrig[k];
        selMode = cfgDelivMode[k*3 +: 3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlvValid     <= 1'b0;
      dlvPin       <= '0;
      dlvVector    <= '0;
      dlvDest      <= '0;
      dlvDestMode  <= 1'b0;
      dlvDelivMode <= '0;
      dlvLevel     <= 1'b0;
    end else begin
      dlvValid <= strobe.grantValid;
      if (strobe.grantValid) begin
        dlvPin       <= selPin;
        dlvVector    <= selVec;
        dlvDest      <= selDest;
        dlvDestMode  <= selDm;
        dlvDelivMode <= selMode;
        dlvLevel     <= selLvl;
      end
    end
  end
endmodule

// File: rtl/irqsvc_ctrl.sv
module irqsvc_ctrl
  import irqsvc_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DLY_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] eligible,
  input  logic                stormAny,
  input  logic [DLY_W-1:0]    delayCycles,
  output svcStrobe_t          strobe
);
  logic [DLY_W-1:0] dlyCnt;
  logic             dlyActive;
  logic             dlyExpire;

  assign dlyExpire = dlyActive && (dlyCnt == DLY_W'(1));

  // Lowest eligible pin wins: scan from the top so the last hit is the lowest
  always_comb begin
    strobe.grantValid = 1'b0;
    strobe.grantPin   = '0;
    for (int k = NUM_PINS - 1; k >= 0; k--) begin
      if (eligible[k]) begin
        strobe.grantValid = 1'b1;
        strobe.grantPin   = PIN_IDX_W'(k);
      end
    end
    strobe.delayFire = dlyExpire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlyActive <= 1'b0;
      dlyCnt    <= '0;
    end else if (dlyActive) begin
      if (dlyExpire) dlyActive <= 1'b0;
      else           dlyCnt    <= dlyCnt - 1'b1;
    end else if (stormAny) begin
      dlyActive <= 1'b1;
      dlyCnt    <= (delayCycles == '0) ? DLY_W'(1) : delayCycles;
    end
  end
endmodule

// File: rtl/irq_service_engine.sv
module irq_service_engine
  import irqsvc_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int VEC_W       = 8,
  parameter int DEST_W      = 8,
  parameter int STORM_LIMIT = 10000,
  parameter int DLY_W       = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PINS-1:0]        reqRaise,
  input  logic [NUM_PINS-1:0]        reqDrop,
  input  logic [NUM_PINS*VEC_W-1:0]  cfgVector,
  input  logic [NUM_PINS*DEST_W-1:0] cfgDest,
  input  logic [NUM_PINS*3-1:0]      cfgDelivMode,
  input  logic [NUM_PINS-1:0]        cfgDestMode,
  input  logic [NUM_PINS-1:0]        cfgLevelTrig,
  input  logic [NUM_PINS-1:0]        cfgMask,
  input  logic [NUM_PINS-1:0]        cfgWrite,
  input  logic                       eoiValid,
  input  logic [VEC_W-1:0]           eoiVector,
  input  logic [DLY_W-1:0]           delayCycles,
  output logic                       dlvValid,
  output logic [((NUM_PINS > 1) ? $clog2(NUM_PINS) : 1)-1:0] dlvPin,
  output logic [VEC_W-1:0]           dlvVector,
  output logic [DEST_W-1:0]          dlvDest,
  output logic                       dlvDestMode,
  output logic [2:0]                 dlvDelivMode,
  output logic                       dlvLevel,
  output logic [NUM_PINS-1:0]        remoteIrr,
  output logic [NUM_PINS-1:0]        reqState
);
  svcStrobe_t          strobe;
  logic [NUM_PINS-1:0] eligible;
  logic                stormAny;

  irqsvc_ctrl #(.NUM_PINS(NUM_PINS), .DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .stormAny(stormAny),
    .delayCycles(delayCycles), .strobe(strobe)
  );

  irqsvc_dp #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W),
              .STORM_LIMIT(STORM_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .reqRaise(reqRaise), .reqDrop(reqDrop),
    .cfgVector(cfgVector), .cfgDest(cfgDest), .cfgDelivMode(cfgDelivMode),
    .cfgDestMode(cfgDestMode), .cfgLevelTrig(cfgLevelTrig), .cfgMask(cfgMask),
    .cfgWrite(cfgWrite), .eoiValid(eoiValid), .eoiVector(eoiVector),
    .strobe(strobe), .eligible(eligible), .stormAny(stormAny),
    .dlvValid(dlvValid), .dlvPin(dlvPin), .dlvVector(dlvVector),
    .dlvDest(dlvDest), .dlvDestMode(dlvDestMode), .dlvDelivMode(dlvDelivMode),
    .dlvLevel(dlvLevel), .remoteIrr(remoteIrr), .reqState(reqState)
  );
endmodule

// File: rtl/irqsvc_checker.sv
module irqsvc_checker #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] reqRaise,
  input logic [NUM_PINS-1:0] reqDrop,
  input logic [NUM_PINS-1:0] cfgMask,
  input logic [NUM_PINS-1:0] cfgLevelTrig,
  input logic [NUM_PINS-1:0] cfgWrite,
  input logic                dlvValid,
  input logic [((NUM_PINS > 1) ? $clog2(NUM_PINS) : 1)-1:0] dlvPin,
  input logic                dlvLevel,
  input logic [NUM_PINS-1:0] remoteIrr,
  input logic [NUM_PINS-1:0] reqState
);
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [NUM_PINS-1:0] prevMask, prevRirr;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevMask <= '0;
      prevRirr <= '0;
    end else begin
      prevMask <= cfgMask;
      prevRirr <= remoteIrr;
    end
  end

  AST_MASKED_NO_DLV: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid |-> !prevMask[dlvPin]); // R3
  AST_RIRR_BLOCKS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (dlvValid && dlvLevel) |-> !prevRirr[dlvPin]); // R3
  AST_LEVEL_SETS_RIRR: assert property (@(posedge clk) disable iff (!rstN)
    (dlvValid && dlvLevel) |-> remoteIrr[dlvPin]); // R4

  genvar i;
  for (i = 0; i < NUM_PINS; i++) begin : g_pin_chk
    AST_RIRR_ONLY_BY_DLV: assert property (@(posedge clk) disable iff (!rstN)
      $rose(remoteIrr[i]) |-> (dlvValid && dlvPin == PIN_W'(i))); // R4
    AST_DROP_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rstN)
      (reqDrop[i] && !reqRaise[i]) |=> !reqState[i]); // R1
    AST_EDGE_WRITE_CLR: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWrite[i] && !cfgLevelTrig[i]) |=> !remoteIrr[i]); // R8
  end
endmodule

bind irq_service_engine irqsvc_checker #(.NUM_PINS(NUM_PINS)) u_irqsvc_checker (
  .clk(clk), .rstN(rstN), .reqRaise(reqRaise), .reqDrop(reqDrop),
  .cfgMask(cfgMask), .cfgLevelTrig(cfgLevelTrig), .cfgWrite(cfgWrite),
  .dlvValid(dlvValid), .dlvPin(dlvPin), .dlvLevel(dlvLevel),
  .remoteIrr(remoteIrr), .reqState(reqState)
);

// File: tb/irq_service_engine_bench.sv
`timescale 1ns/1ps
module irq_service_engine_bench;
  localparam int NP = 4, VW = 8, DW = 8, LIM = 4, DLYW = 8, DLY = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [NP-1:0] reqRaise = '0, reqDrop = '0, cfgWrite = '0;
  logic [NP-1:0] maskR, lvlR, dmR;
  logic [VW-1:0] vecA [NP];
  logic [DW-1:0] destA [NP];
  logic [2:0]    modeA [NP];
  logic          eoiValid = 1'b0;
  logic [VW-1:0] eoiVector = '0;
  logic [NP*VW-1:0] cfgVector;
  logic [NP*DW-1:0] cfgDest;
  logic [NP*3-1:0]  cfgDelivMode;

  always_comb begin
    for (int k = 0; k < NP; k++) begin
      cfgVector[k*VW +: VW]  = vecA[k];
      cfgDest[k*DW +: DW]    = destA[k];
      cfgDelivMode[k*3 +: 3] = modeA[k];
    end
  end

  logic          dlvValid, dlvDestMode, dlvLevel;
  logic [1:0]    dlvPin;
  logic [VW-1:0] dlvVector;
  logic [DW-1:0] dlvDest;
  logic [2:0]    dlvDelivMode;
  logic [NP-1:0] remoteIrr, reqState;

  irq_service_engine #(.NUM_PINS(NP), .VEC_W(VW), .DEST_W(DW),
                       .STORM_LIMIT(LIM), .DLY_W(DLYW)) u_irq_service_engine (
    .clk(clk), .rstN(rstN), .reqRaise(reqRaise), .reqDrop(reqDrop),
    .cfgVector(cfgVector), .cfgDest(cfgDest), .cfgDelivMode(cfgDelivMode),
    .cfgDestMode(dmR), .cfgLevelTrig(lvlR), .cfgMask(maskR), .cfgWrite(cfgWrite),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .delayCycles(DLYW'(DLY)),
    .dlvValid(dlvValid), .dlvPin(dlvPin), .dlvVector(dlvVector), .dlvDest(dlvDest),
    .dlvDestMode(dlvDestMode), .dlvDelivMode(dlvDelivMode), .dlvLevel(dlvLevel),
    .remoteIrr(remoteIrr), .reqState(reqState)
  );

  int checks = 0, failures = 0;
  logic [22:0] sbQ [$];

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expectDlv(input int p);
    sbQ.push_back({2'(p), vecA[p], destA[p], dmR[p], modeA[p], lvlR[p]});
  endtask

  // Monitor: every delivery must match the oldest expected item (R11, R10 order)
  always @(negedge clk) begin
    if (rstN && dlvValid) begin
      logic [22:0] got;
      got = {dlvPin, dlvVector, dlvDest, dlvDestMode, dlvDelivMode, dlvLevel};
      if (sbQ.size() == 0) begin
        check(1'b0, "R2/R3 unexpected delivery", longint'(got), 0);
      end else begin
        logic [22:0] e;
        e = sbQ.pop_front();
        check(got == e, "R11/R10 delivery content or order", longint'(got), longint'(e));
      end
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic checkEmpty(input string tag);
    check(sbQ.size() == 0, tag, sbQ.size(), 0);
  endtask

  task automatic raise(input logic [NP-1:0] m);
    @(negedge clk) reqRaise = m;
    @(negedge clk) reqRaise = '0;
  endtask

  task automatic drop(input logic [NP-1:0] m);
    @(negedge clk) reqDrop = m;
    @(negedge clk) reqDrop = '0;
  endtask

  task automatic eoi(input logic [VW-1:0] v);
    @(negedge clk) begin eoiValid = 1'b1; eoiVector = v; end
    @(negedge clk) eoiValid = 1'b0;
  endtask

  task automatic setEntry(input int p, input logic lvl, input logic msk);
    @(negedge clk) begin lvlR[p] = lvl; maskR[p] = msk; cfgWrite[p] = 1'b1; end
    @(negedge clk) cfgWrite = '0;
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    vecA[0] = 8'h30; destA[0] = 8'h01; modeA[0] = 3'd0;
    vecA[1] = 8'h41; destA[1] = 8'h02; modeA[1] = 3'd1;
    vecA[2] = 8'h52; destA[2] = 8'h03; modeA[2] = 3'd2;
    vecA[3] = 8'h63; destA[3] = 8'h04; modeA[3] = 3'd3;
    lvlR  = 4'b1110;
    maskR = 4'b1100;
    dmR   = 4'b0010;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    settle(2);
    // R12: reset state
    check(dlvValid == 1'b0, "R12 dlvValid after reset", dlvValid, 0);
    check(remoteIrr == '0, "R12 remoteIrr after reset", remoteIrr, 0);
    check(reqState == '0, "R12 reqState after reset", reqState, 0);

    // R11 timing and R2 first edge delivery
    expectDlv(0);
    raise(4'b0001);
    #1 check(dlvValid == 1'b0, "R11 no output one edge after strobe", dlvValid, 0);
    settle(1);
    check(dlvValid == 1'b1, "R11 output two edges after strobe", dlvValid, 1);
    settle(3);
    checkEmpty("R2 edge delivery missing");
    check(remoteIrr[0] == 1'b0, "R4 edge pin leaves remote flag", remoteIrr[0], 0);

    // R2 coalescing
    raise(4'b0001);
    settle(4);
    checkEmpty("R2 coalesced raise");
    check(reqState[0] == 1'b1, "R2 request bit held", reqState[0], 1);

    // R1 drop then re-raise
    drop(4'b0001);
    settle(2);
    check(reqState[0] == 1'b0, "R1 drop clears request", reqState[0], 0);
    expectDlv(0);
    raise(4'b0001);
    settle(4);
    checkEmpty("R2 re-armed edge delivery");

    // R4 level delivery sets remote flag
    expectDlv(1);
    raise(4'b0010);
    settle(4);
    checkEmpty("R4 level delivery missing");
    check(remoteIrr == 4'b0010, "R4 remote flag set", remoteIrr, 4'b0010);

    // R3 refused by remote flag, and by mask
    raise(4'b0010);
    settle(4);
    checkEmpty("R3 blocked by remote flag");
    raise(4'b0100);
    settle(4);
    check(reqState[2] == 1'b1, "R3 masked pin still requests", reqState[2], 1);
    @(negedge clk) maskR[2] = 1'b0;
    settle(4);
    checkEmpty("R3 discarded attempt stays discarded");
    check(remoteIrr[2] == 1'b0, "R3 masked pin remote flag", remoteIrr[2], 0);

    // R5 acknowledgment and redelivery
    expectDlv(1);
    eoi(8'h41);
    settle(4);
    checkEmpty("R5 redelivery missing");
    check(remoteIrr[1] == 1'b1, "R5 remote flag set again", remoteIrr[1], 1);
    eoi(8'h30);
    settle(4);
    checkEmpty("R5 edge vector ack ignored");
    eoi(8'h99);
    settle(4);
    check(remoteIrr[1] == 1'b1, "R5 other vector ignored", remoteIrr[1], 1);

    // R7 ack with line low clears flag and count
    drop(4'b0010);
    eoi(8'h41);
    settle(4);
    checkEmpty("R7 no redelivery with line low");
    check(remoteIrr[1] == 1'b0, "R7 remote flag cleared", remoteIrr[1], 0);

    // R6 storm: LIM-1 immediate redeliveries then deferral; R9 deferred service; R10 order
    expectDlv(1);
    raise(4'b0010);
    settle(4);
    for (int k = 0; k < LIM - 1; k++) begin
      expectDlv(1);
      eoi(8'h41);
      settle(4);
    end
    checkEmpty("R6 redeliveries before limit");
    eoi(8'h41);
    settle(DLY - 4);
    checkEmpty("R6 deferral holds delivery");
    check(remoteIrr[1] == 1'b0, "R6 remote flag clear during deferral", remoteIrr[1], 0);
    expectDlv(1);
    expectDlv(2);
    settle(8);
    checkEmpty("R9 deferred service missing");
    check(remoteIrr == 4'b0110, "R9 deferred pins flagged", remoteIrr, 4'b0110);

    // R8 level rewrite triggers attempt; edge rewrite clears flag
    raise(4'b1000);
    settle(4);
    checkEmpty("R8 masked pin refused");
    expectDlv(3);
    setEntry(3, 1'b1, 1'b0);
    settle(4);
    checkEmpty("R8 rewrite attempt missing");
    check(remoteIrr[3] == 1'b1, "R8 rewrite delivery sets flag", remoteIrr[3], 1);
    setEntry(1, 1'b0, 1'b0);
    settle(2);
    check(remoteIrr[1] == 1'b0, "R8 edge rewrite clears flag", remoteIrr[1], 0);
    checkEmpty("R8 edge rewrite no attempt");

    // R10 simultaneous raises, lowest first
    drop(4'b1001);
    eoi(8'h63);
    settle(3);
    expectDlv(0);
    expectDlv(3);
    raise(4'b1001);
    settle(5);
    checkEmpty("R10 simultaneous deliveries");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule